// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a 16-bit up-counting timer that drives one pulse-width-modulated output. One compare value sets the period and a second sets the point in the period where the output falls. The counter advances only on cycles where a prescaled clock enable is high. In a normal system that enable is the base clock divided by four. Each time the counter wraps, the block can raise a one-cycle interrupt pulse.

Each compare register has a shadow copy. In double-buffer mode the counter is matched against the shadows, not against the registers software writes. A shadow takes a new value from its register only when the counter reaches the shadow's current value, so a new setting never lands in the middle of a period. Software can also write any data to a shadow's address. That copies the register into the shadow at once, which primes both shadows before counting starts. With double buffering off, the counter is matched against the written registers directly.

Writes use a single 16-bit port with a 3-bit select. Select 0 is the mode word: bit 0 is run enable, bit 1 is interrupt enable and bit 2 is double-buffer mode. Select 1 is the period compare (A) and select 2 is the duty compare (B). Select 3 is the shadow-A load strobe and select 4 is the shadow-B load strobe. The control is a three-state machine:
- OFF: stopped, counter 0, output low.
- HIGH: running with the output high.
- LOW: running with the output low.

Its transitions are:
- START (OFF to HIGH) on the first cycle with run enable set.
- FALL (HIGH to LOW) on a tick where the count equals effective B.
- WRAP (HIGH or LOW to HIGH) on a tick where the count equals effective A.
- STOP (any running state to OFF) when run enable is clear.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset the output and the interrupt are low, both compare shadows are 0, compare A is 1, compare B is 0 and the mode word is 0.
- R2: One cycle after run enable (mode bit 0) becomes set, the machine takes START: the output goes high and the counter sits at 0.
- R3: While running, the counter rises by one on each cycle with the tick enable high and holds on every other cycle. With no ticks the output and the interrupt do not change.
- R4: On a tick where the count equals effective A, the counter wraps to 0 and the output is set (WRAP). The period is therefore A+1 ticks: A=4 gives one interrupt every 5 ticks.
- R5: On a tick where the count equals effective B (and not A), the output is cleared (FALL). The output is high for B+1 ticks of each period, so A=4 and B=1 give a duty of 2/5.
- R6: The interrupt is a one-cycle pulse in the cycle after a WRAP tick, but only when mode bit 1 is set. With bit 1 clear, no pulse appears.
- R7: A write of 0x0000 or 0xFFFF to compare A (select 1) is ignored, and the previous value stays.
- R8: A write to compare B (select 2) that is not strictly below the current compare A is ignored.
- R9: With mode bit 2 set, the counter is matched against the shadows. Shadow A reloads from compare A when the count equals shadow A, and shadow B reloads from compare B when the count equals shadow B.
- R10: A write of any data to select 3 or select 4 copies compare A or compare B, respectively, into its shadow on that clock.
- R11: With mode bit 2 clear, the counter is matched against compare A and compare B directly, so a written value applies from the next cycle.
- R12: When run enable is clear, the machine takes STOP. The counter and the output are cleared on the next clock and stay cleared while ticks continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0 mode, 1 A, 2 B, 3 shadow-A load, 4 shadow-B load) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Period interrupt pulse |

## Verification
The waveform is measured over fixed 100-cycle windows that start at START. High-cycle and interrupt counts are taken for four setups:
- A=4, B=1 direct.
- A=9, B=4 direct.
- A=4, B=1 primed into the shadows, followed by an unprimed rewrite to A=9, B=4 in double-buffer mode.
- The same rewrite after an explicit shadow load.

The third window expects 52 high cycles and 10 pulses, against 50 and 9 for direct mode, which separates "reload at the old match" from "apply at once". Repeating the 4/1 window after rejected A and B writes shows that the out-of-range values left nothing behind. Ticks arrive every cycle, every fourth cycle or never, and a reference model is compared on every clock to catch slips in the hold and step behaviour.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] SEL_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_LDA  = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_LDB  = 3'd4;

    localparam int MB_RUN  = 0;
    localparam int MB_IRQ  = 1;
    localparam int MB_DBUF = 2;
    localparam int MODE_W  = 3;

    localparam int N_CMP = 2;
    localparam int CH_A  = 0;
    localparam int CH_B  = 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              run_en,
    output logic              irq_en,
    output logic              dbuf_en,
    output logic [W-1:0]      cmp_a_q,
    output logic [W-1:0]      cmp_b_q,
    output logic              ld_a_wr,
    output logic              ld_b_wr
);

    localparam logic [W-1:0] A_RST = W'(1);

    logic [MODE_W-1:0] mode_q;
    logic              a_ok;
    logic              b_ok;

    // range checks on incoming compare data
    assign a_ok = (wr_data != '0) && !(&wr_data);
    assign b_ok = (wr_data < cmp_a_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            cmp_a_q <= A_RST;
            cmp_b_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                SEL_MODE: mode_q <= wr_data[MODE_W-1:0];
                SEL_CMPA: if (a_ok) cmp_a_q <= wr_data;
                SEL_CMPB: if (b_ok) cmp_b_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign run_en  = mode_q[MB_RUN];
    assign irq_en  = mode_q[MB_IRQ];
    assign dbuf_en = mode_q[MB_DBUF];

    assign ld_a_wr = wr_en && (wr_addr == SEL_LDA);
    assign ld_b_wr = wr_en && (wr_addr == SEL_LDB);

endmodule

// File: rtl/pwm_tmr_shadow.sv
module pwm_tmr_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dbuf_en,
    input  logic         load_wr,
    input  logic         load_hit,
    input  logic [W-1:0] cmp_q,
    output logic [W-1:0] cmp_eff
);

    logic [W-1:0] shadow_q;
    logic         take;

    // explicit strobe always loads; a match loads only in buffered mode
    assign take = load_wr || (load_hit && dbuf_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (take) begin
            shadow_q <= cmp_q;
        end
    end

    assign cmp_eff = dbuf_en ? shadow_q : cmp_q;

endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
    import pwm_tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         irq_en,
    input  logic         tick_en,
    input  logic [W-1:0] cmp_a_eff,
    input  logic [W-1:0] cmp_b_eff,
    output logic [W-1:0] cnt_q,
    output pwm_state_e   state_q,
    output logic         hit_a,
    output logic         hit_b,
    output logic         pwm_out,
    output logic         irq
);

    pwm_state_e state_d;
    logic       running;

    assign running = run_en && (state_q != ST_OFF);
    assign hit_a   = running && tick_en && (cnt_q == cmp_a_eff);
    assign hit_b   = running && tick_en && (cnt_q == cmp_b_eff);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, FALL, WRAP, STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_en) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!run_en)    state_d = ST_OFF;
                else if (hit_a) state_d = ST_HIGH;
                else if (hit_b) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!run_en)    state_d = ST_OFF;
                else if (hit_a) state_d = ST_HIGH;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // counter and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= hit_a && irq_en;
            if (!running) begin
                cnt_q <= '0;
            end else if (tick_en) begin
                cnt_q <= hit_a ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pwm_out = (state_q == ST_HIGH);
    end

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic              irq
);

    logic             run_en;
    logic             irq_en;
    logic             dbuf_en;
    logic [CNT_W-1:0] cmp_a_q;
    logic [CNT_W-1:0] cmp_b_q;
    logic             ld_a_wr;
    logic             ld_b_wr;
    logic [CNT_W-1:0] cmp_a_eff;
    logic [CNT_W-1:0] cmp_b_eff;
    logic [CNT_W-1:0] cnt_q;
    pwm_state_e       state_q;
    logic             hit_a;
    logic             hit_b;

    logic [CNT_W-1:0] ch_cmp [N_CMP];
    logic [CNT_W-1:0] ch_eff [N_CMP];
    logic             ch_ldw [N_CMP];
    logic             ch_hit [N_CMP];

    pwm_tmr_regs #(.W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run_en  (run_en),
        .irq_en  (irq_en),
        .dbuf_en (dbuf_en),
        .cmp_a_q (cmp_a_q),
        .cmp_b_q (cmp_b_q),
        .ld_a_wr (ld_a_wr),
        .ld_b_wr (ld_b_wr)
    );

    assign ch_cmp[CH_A] = cmp_a_q;
    assign ch_cmp[CH_B] = cmp_b_q;
    assign ch_ldw[CH_A] = ld_a_wr;
    assign ch_ldw[CH_B] = ld_b_wr;
    assign ch_hit[CH_A] = hit_a;
    assign ch_hit[CH_B] = hit_b;

    for (genvar c = 0; c < N_CMP; c++) begin : g_shd
        pwm_tmr_shadow #(.W(CNT_W)) u_shd (
            .clk      (clk),
            .rst_n    (rst_n),
            .dbuf_en  (dbuf_en),
            .load_wr  (ch_ldw[c]),
            .load_hit (ch_hit[c]),
            .cmp_q    (ch_cmp[c]),
            .cmp_eff  (ch_eff[c])
        );
    end

    assign cmp_a_eff = ch_eff[CH_A];
    assign cmp_b_eff = ch_eff[CH_B];

    pwm_tmr_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .irq_en    (irq_en),
        .tick_en   (tick_en),
        .cmp_a_eff (cmp_a_eff),
        .cmp_b_eff (cmp_b_eff),
        .cnt_q     (cnt_q),
        .state_q   (state_q),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

endmodule

// File: rtl/pwm_dbuf_timer_chk.sv
module pwm_dbuf_timer_chk
    import pwm_tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic              run_en,
    input pwm_state_e        state_q,
    input logic [W-1:0]      cnt_q,
    input logic [W-1:0]      cmp_a_eff,
    input logic [W-1:0]      cmp_a_q,
    input logic [W-1:0]      cmp_b_q,
    input logic              pwm_out,
    input logic              irq
);

    localparam logic [W-1:0] ONE = W'(1);

    logic live;
    assign live = run_en && (state_q != ST_OFF);

    a_r12_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0 && !pwm_out));

    a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state_q == ST_OFF) |=> (pwm_out && cnt_q == '0));

    a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (live && tick_en && cnt_q != cmp_a_eff) |=> (cnt_q == $past(cnt_q) + ONE));

    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !tick_en) |=> $stable(cnt_q));

    a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (live && tick_en && cnt_q == cmp_a_eff) |=> (cnt_q == '0 && pwm_out));

    a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick_en));

    a_r7_bad_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_CMPA && (wr_data == '0 || &wr_data)) |=> $stable(cmp_a_q));

    a_r8_bad_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_CMPB && wr_data >= cmp_a_q) |=> $stable(cmp_b_q));

endmodule

bind pwm_dbuf_timer pwm_dbuf_timer_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .run_en    (run_en),
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .cmp_a_eff (cmp_a_eff),
    .cmp_a_q   (cmp_a_q),
    .cmp_b_q   (cmp_b_q),
    .pwm_out   (pwm_out),
    .irq       (irq)
);

// File: tb/pwm_dbuf_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int tick_div = 0;
    int tc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_dbuf_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out),
        .irq     (irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // tick generator: 0 none, 1 every cycle, 4 every fourth cycle
    always @(negedge clk) begin
        tc = (tc + 1) % 4;
        tick_en = (tick_div == 1) || (tick_div == 4 && tc == 0);
    end

    // behavioural reference model (state 0 off, 1 high, 2 low)
    int m_en, m_ie, m_db, m_ra, m_rb, m_sa, m_sb, m_cnt, m_st, m_irq;
    always @(posedge clk) begin
        int ea, eb, n_cnt, n_st, n_sa, n_sb, n_irq, d;
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_db = 0; m_ra = 1; m_rb = 0;
            m_sa = 0; m_sb = 0; m_cnt = 0; m_st = 0; m_irq = 0;
        end else begin
            ea = m_db ? m_sa : m_ra;
            eb = m_db ? m_sb : m_rb;
            n_cnt = m_cnt; n_st = m_st; n_sa = m_sa; n_sb = m_sb; n_irq = 0;
            if (m_en == 0) begin
                n_st = 0; n_cnt = 0;
            end else if (m_st == 0) begin
                n_st = 1; n_cnt = 0;
            end else if (tick_en) begin
                if (m_cnt == ea) begin
                    n_cnt = 0; n_st = 1; n_irq = m_ie;
                    if (m_db) n_sa = m_ra;
                end else begin
                    n_cnt = (m_cnt + 1) % 65536;
                    if (m_cnt == eb) n_st = 2;
                end
                if (m_db && m_cnt == eb) n_sb = m_rb;
            end
            if (wr_en) begin
                d = int'(wr_data);
                case (wr_addr)
                    3'd0: begin m_en = d & 1; m_ie = (d >> 1) & 1; m_db = (d >> 2) & 1; end
                    3'd1: if (d != 0 && d != 65535) m_ra = d;
                    3'd2: if (d < m_ra) m_rb = d;
                    3'd3: n_sa = m_ra;
                    3'd4: n_sb = m_rb;
                    default: ;
                endcase
            end
            m_cnt = n_cnt; m_st = n_st; m_sa = n_sa; m_sb = n_sb; m_irq = n_irq;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pwm_out == (m_st == 1), "R5 pwm vs model", int'(pwm_out), int'(m_st == 1));
            chk(irq == m_irq[0], "R6 irq vs model", int'(irq), m_irq);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int hi, output int pulses, output int first);
        hi = 0; pulses = 0; first = -1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (i == 0) first = int'(pwm_out);
            hi += int'(pwm_out);
            pulses += int'(irq);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R3 watchdog: actual %0d cycles expected completion", 40000);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int hi, pl, fs, p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R1 reset pwm", int'(pwm_out), 0);
        chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);

        // warm-up run with slow ticks, then fast ticks
        tick_div = 4;
        wr(3'd1, 16'd4);
        wr(3'd2, 16'd1);
        wr(3'd0, 16'h3);
        repeat (80) @(negedge clk);
        tick_div = 1;
        repeat (40) @(negedge clk);

        // R12 stop
        wr(3'd0, 16'h0);
        @(negedge clk);
        chk(pwm_out == 1'b0, "R12 stop clears pwm", int'(pwm_out), 0);
        hi = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); hi += int'(pwm_out); end
        chk(hi == 0, "R12 stays low with ticks", hi, 0);

        // A=4 B=1 direct
        wr(3'd0, 16'h3);
        measure(hi, pl, fs);
        chk(fs == 1, "R2 start high", fs, 1);
        chk(hi == 40, "R5 duty 2/5", hi, 40);
        chk(pl == 19, "R4 period 5 pulses", pl, 19);

        // R6 interrupt disabled
        wr(3'd0, 16'h0);
        wr(3'd0, 16'h1);
        measure(hi, pl, fs);
        chk(pl == 0, "R6 no irq when disabled", pl, 0);
        chk(hi == 40, "R6 duty unchanged", hi, 40);

        // R7 / R8 rejected writes
        wr(3'd0, 16'h0);
        wr(3'd1, 16'h0000);
        wr(3'd1, 16'hFFFF);
        wr(3'd2, 16'd4);
        wr(3'd2, 16'd9);
        wr(3'd0, 16'h3);
        measure(hi, pl, fs);
        chk(pl == 19, "R7 bad A ignored", pl, 19);
        chk(hi == 40, "R8 bad B ignored", hi, 40);

        // R3 no ticks: outputs frozen
        tick_div = 0;
        @(negedge clk);
        @(negedge clk);
        p0 = int'(pwm_out);
        hi = 0; pl = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            hi += (int'(pwm_out) != p0) ? 1 : 0;
            pl += int'(irq);
        end
        chk(hi == 0, "R3 pwm holds without ticks", hi, 0);
        chk(pl == 0, "R3 no irq without ticks", pl, 0);
        tick_div = 1;

        // R11 direct A=9 B=4
        wr(3'd0, 16'h0);
        wr(3'd1, 16'd9);
        wr(3'd2, 16'd4);
        wr(3'd0, 16'h3);
        measure(hi, pl, fs);
        chk(hi == 50, "R11 direct duty", hi, 50);
        chk(pl == 9, "R11 direct period", pl, 9);
        wr(3'd1, 16'd6);
        repeat (30) @(negedge clk);

        // R9 buffered: primed 4/1, rewritten to 9/4 before start
        wr(3'd0, 16'h0);
        wr(3'd1, 16'd4);
        wr(3'd2, 16'd1);
        wr(3'd3, 16'h1234);
        wr(3'd4, 16'hBEEF);
        wr(3'd1, 16'd9);
        wr(3'd2, 16'd4);
        wr(3'd0, 16'h7);
        measure(hi, pl, fs);
        chk(hi == 52, "R9 old shadow first period", hi, 52);
        chk(pl == 10, "R9 reload at match", pl, 10);

        // R10 explicit shadow loads
        wr(3'd0, 16'h0);
        wr(3'd3, 16'h0);
        wr(3'd4, 16'hFFFF);
        wr(3'd0, 16'h7);
        measure(hi, pl, fs);
        chk(hi == 50, "R10 strobe loads B", hi, 50);
        chk(pl == 9, "R10 strobe loads A", pl, 9);

        // buffered mid-run rewrite, slow ticks, model compared
        tick_div = 4;
        wr(3'd1, 16'd6);
        wr(3'd2, 16'd2);
        repeat (200) @(negedge clk);
        wr(3'd1, 16'd3);
        repeat (120) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule